// File: doc/BRIEF.md
# HDLC Receive Address and CRC Filter

This block sits in an HDLC receive path after flag hunting and zero-bit deletion. It takes in a byte stream with start and end markers and judges each frame twice. The first byte is the station address, which is compared with a programmed value. A CRC-16 or CRC-32 frame check is also run over the whole frame, including its trailing check bytes. Bytes of accepted frames leave as a filtered stream that carries an end marker. A one-cycle status pulse reports the outcome of each frame.

A short delay line holds back the last two or four bytes, one per check byte. The block can therefore drop the check bytes once the end of the frame is known, or append them when the selected policy calls for it. Frames whose address is rejected leave no bytes on the output. For a frame that fails the check, the check bytes are withheld by default, and the error status tells the downstream frame store to drop what it has collected.

Top module: `hdlcRxFilter`

## Requirements
- R1: A frame whose first byte equals `cfgAddr` is forwarded. The output bytes start with that address byte and keep the input order.
- R2: A frame whose first byte differs from `cfgAddr` puts no byte on the output, when that byte is not 0xFF and `cfgAddr` is not 0xFF. Its status code is 3 (address rejected).
- R3: A frame whose first byte is 0xFF is accepted whatever value `cfgAddr` holds.
- R4: When `cfgAddr` is 0xFF, every frame is accepted whatever its first byte.
- R5: With `cfgCrcType` = 1, the check is CRC-16 with polynomial x^16+x^12+x^5+1. The bits are taken LSB first, the register starts at all ones, and the check bytes are the sent complement, low byte first. In the default policy a good frame reports code 1 (good), its two check bytes are removed, and `outLast` marks the last byte before them.
- R6: With `cfgCrcType` = 2, the standard 32-bit CCITT check is applied in the same bit order and preset, over four check bytes. A good frame reports code 1, and its check bytes are removed in the default policy.
- R7: With `cfgCrcType` = 0 (or the spare value 3), no check is made. Every byte of an accepted frame is passed, including a one-byte frame, and the status is code 1.
- R8: In the default policy (`cfgRetCrc` = 0, `cfgRetCrcOnErr` = 0), a frame that fails the check reports code 2 (CRC error). Its check bytes are not delivered.
- R9: With `cfgRetCrc` = 1, good and failing frames are both delivered with their received check bytes appended, and `outLast` is on the final check byte. This setting takes precedence over `cfgRetCrcOnErr`.
- R10: With only `cfgRetCrcOnErr` = 1, a failing frame is delivered with its check bytes appended, while a good frame is delivered with them removed.
- R11: Exactly one status pulse is given per frame, one cycle after the frame's last input byte is taken. The codes are 1 good, 2 CRC error and 3 address rejected.
- R12: After reset `outValid`, `outLast` and `statValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte present |
| inSof | input | 1 | Input byte is the first of a frame |
| inEof | input | 1 | Input byte is the last of a frame |
| inData | input | 8 | Input byte |
| cfgAddr | input | 8 | Station address; 0xFF accepts all |
| cfgCrcType | input | 2 | 0 none, 1 CRC-16, 2 CRC-32, 3 none |
| cfgRetCrc | input | 1 | Append check bytes to every frame |
| cfgRetCrcOnErr | input | 1 | Append check bytes only to failing frames |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Output byte ends the frame |
| statValid | output | 1 | Status pulse, one per frame |
| statCode | output | 2 | 1 good, 2 CRC error, 3 address rejected |

## Verification
The address filter is driven with a matching address, a mismatching one, the broadcast byte against a set address, and an arbitrary byte against the all-ones setting. Together these separate an exact compare, the broadcast override and the disable. The frame check is run with correct and single-bit-corrupted check bytes for both polynomials and with no check. Each corrupted and good frame is run under each return policy, so that the count and position of delivered bytes show whether the check bytes were stripped or appended. One-byte frames cover the case where the end marker arrives together with the start marker.

// File: rtl/hdlcFiltPkg.sv
package hdlcFiltPkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 32;
  localparam int MAX_FCS_BYTES = 4;
  localparam int FILL_W = $clog2(MAX_FCS_BYTES + 1);
  localparam int SEL_W = $clog2(MAX_FCS_BYTES);
  localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF;

  typedef enum logic [1:0] {
    STAT_NONE = 2'd0, STAT_GOOD = 2'd1, STAT_CRCERR = 2'd2, STAT_ADDRREJ = 2'd3
  } statCode_e;

  typedef enum logic [1:0] {
    CRC_OFF = 2'd0, CRC_16 = 2'd1, CRC_32 = 2'd2, CRC_SPARE = 2'd3
  } crcSel_e;

  typedef struct packed {
    logic push;
    logic emit;
    logic useIn;
    logic last;
    logic [SEL_W-1:0] sel;
  } dpCmd_t;

  function automatic logic [FILL_W-1:0] fcsBytes(crcSel_e s);
    case (s)
      CRC_16:  return FILL_W'(2);
      CRC_32:  return FILL_W'(4);
      default: return FILL_W'(0);
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] crcPreset(logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [CRC_W-1:0] crcByte(logic [CRC_W-1:0] c, logic [BYTE_W-1:0] d,
                                              logic wide);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
    end
    return r;
  endfunction

  function automatic logic crcResidueOk(logic [CRC_W-1:0] c, logic wide);
    return wide ? (c == 32'hDEBB_20E3) : (c[15:0] == 16'hF0B8);
  endfunction
endpackage

// File: rtl/hdlcFiltCtrl.sv
module hdlcFiltCtrl
  import hdlcFiltPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [BYTE_W-1:0] inData,
  input  logic [BYTE_W-1:0] cfgAddr,
  input  logic [1:0]        cfgCrcType,
  input  logic              cfgRetCrc,
  input  logic              cfgRetCrcOnErr,
  output dpCmd_t            cmd,
  output logic              statValid,
  output logic [1:0]        statCode
);
  logic inFrame, frameAcc;
  logic [CRC_W-1:0] crcReg, crcNext;
  logic [FILL_W-1:0] fill, fillEff, fillNext, depth, depthM1, flushCnt, flushM1;
  crcSel_e crcSel;
  logic wide, addrOk, flushing, accNow, liveNow, byteAcc, rejEof, eofAcc;
  logic crcGood, keepFcs;

  always_comb begin
    crcSel   = crcSel_e'(cfgCrcType);
    wide     = (crcSel == CRC_32);
    depth    = fcsBytes(crcSel);
    depthM1  = depth - FILL_W'(1);
    flushM1  = flushCnt - FILL_W'(1);
    addrOk   = (inData == BCAST_ADDR) || (cfgAddr == BCAST_ADDR) || (inData == cfgAddr);
    flushing = (flushCnt != '0);
    accNow   = inSof ? addrOk : frameAcc;
    liveNow  = inSof || inFrame;
    byteAcc  = inValid && liveNow && accNow;
    rejEof   = inValid && inEof && liveNow && !accNow;
    eofAcc   = byteAcc && inEof;
    fillEff  = inSof ? '0 : fill;
    fillNext = (fillEff >= depth) ? depth : fillEff + FILL_W'(1);
    crcNext  = crcByte(inSof ? crcPreset(wide) : crcReg, inData, wide);
    crcGood  = (depth == '0) || crcResidueOk(crcNext, wide);
    keepFcs  = cfgRetCrc || (!crcGood && cfgRetCrcOnErr);

    cmd = '0;
    if (flushing) begin
      cmd.emit = 1'b1;
      cmd.sel  = flushM1[SEL_W-1:0];
      cmd.last = (flushCnt == FILL_W'(1));
    end else if (byteAcc) begin
      cmd.push  = 1'b1;
      cmd.emit  = (fillEff == depth);
      cmd.useIn = (depth == '0);
      cmd.sel   = depthM1[SEL_W-1:0];
      cmd.last  = (fillEff == depth) && eofAcc && (!keepFcs || depth == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      frameAcc  <= 1'b0;
      crcReg    <= '0;
      fill      <= '0;
      flushCnt  <= '0;
      statValid <= 1'b0;
      statCode  <= STAT_NONE;
    end else begin
      if (inValid) begin
        if (inEof) inFrame <= 1'b0;
        else if (inSof) inFrame <= 1'b1;
      end
      if (inValid && inSof) frameAcc <= addrOk;
      if (byteAcc) begin
        crcReg <= crcNext;
        fill   <= fillNext;
      end
      if (flushing) flushCnt <= flushM1;
      else if (eofAcc && keepFcs && depth != '0) flushCnt <= fillNext;
      statValid <= eofAcc || rejEof;
      statCode  <= rejEof ? STAT_ADDRREJ : (crcGood ? STAT_GOOD : STAT_CRCERR);
    end
  end

  // R9: appended check bytes are flushed from the delay line while input is idle
  assert_no_input_while_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushing |-> !inValid);
  assert_stat_after_eof_R11: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> $past(inValid && inEof));
  assert_stat_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> statCode != STAT_NONE);
endmodule

// File: rtl/hdlcFiltDp.sv
module hdlcFiltDp
  import hdlcFiltPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast
);
  logic [BYTE_W-1:0] line [MAX_FCS_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) line[0] <= '0;
    else if (cmd.push) line[0] <= inData;
  end

  for (genvar i = 1; i < MAX_FCS_BYTES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) line[i] <= '0;
      else if (cmd.push) line[i] <= line[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= cmd.emit;
      outLast  <= cmd.emit && cmd.last;
      if (cmd.emit) outData <= cmd.useIn ? inData : line[cmd.sel];
    end
  end

  assert_last_has_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: rtl/hdlcRxFilter.sv
module hdlcRxFilter
  import hdlcFiltPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic [7:0] inData,
  input  logic [7:0] cfgAddr,
  input  logic [1:0] cfgCrcType,
  input  logic       cfgRetCrc,
  input  logic       cfgRetCrcOnErr,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       statValid,
  output logic [1:0] statCode
);
  dpCmd_t cmd;

  hdlcFiltCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .cfgAddr(cfgAddr), .cfgCrcType(cfgCrcType), .cfgRetCrc(cfgRetCrc),
    .cfgRetCrcOnErr(cfgRetCrcOnErr), .cmd(cmd), .statValid(statValid), .statCode(statCode)
  );

  hdlcFiltDp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inData(inData),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  assert_reject_no_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statCode == 2'd3) |-> !outValid);
endmodule

// File: tb/sim_hdlcRxFilter.sv
module sim_hdlcRxFilter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = '0, cfgAddr = 8'h12;
  logic [1:0] cfgCrcType = 2'd1;
  logic cfgRetCrc = 1'b0, cfgRetCrcOnErr = 1'b0;
  logic outValid, outLast, statValid;
  logic [7:0] outData;
  logic [1:0] statCode;

  int nChk = 0, nFail = 0, cyc = 0;
  int rxCnt, lastCnt, lastIdx, stCnt, statCyc, eofCyc;
  logic [1:0] stCode;
  logic [7:0] rxData [0:31];
  logic [7:0] frm [0:15];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdlcRxFilter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .cfgAddr(cfgAddr), .cfgCrcType(cfgCrcType), .cfgRetCrc(cfgRetCrc),
    .cfgRetCrcOnErr(cfgRetCrcOnErr), .outValid(outValid), .outData(outData),
    .outLast(outLast), .statValid(statValid), .statCode(statCode)
  );

  always @(negedge clk) begin
    if (outValid) begin
      if (rxCnt < 32) rxData[rxCnt] = outData;
      if (outLast) begin lastCnt++; lastIdx = rxCnt; end
      rxCnt++;
    end
    if (statValid) begin stCnt++; stCode = statCode; statCyc = cyc; end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fcsOf(input int n, input bit wide);
    logic [31:0] c;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++)
        if (c[0] ^ frm[b][k]) c = (c >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
        else c = c >> 1;
    return ~c;
  endfunction

  task automatic fillFrm(input logic [7:0] addr, input int p);
    frm[0] = addr;
    for (int i = 1; i < p; i++) frm[i] = 8'(8'h41 + i * 13);
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1'b1; inSof = (i == 0); inEof = (i == n - 1); inData = frm[i];
      if (i == n - 1) eofCyc = cyc;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  // p payload bytes (address first), f check bytes, expected status and policy
  task automatic doFrame(input string req, input int p, input int f, input bit wide,
                         input bit corrupt, input int expStat, input bit keep);
    logic [31:0] fcs;
    int expOut, bad;
    if (f > 0) begin
      fcs = fcsOf(p, wide);
      for (int j = 0; j < f; j++) frm[p + j] = fcs[8 * j +: 8];
      if (corrupt) frm[p] = frm[p] ^ 8'h01;
    end
    rxCnt = 0; lastCnt = 0; lastIdx = -1; stCnt = 0; stCode = 2'd0; statCyc = -1;
    sendBytes(p + f);
    repeat (8) @(posedge clk);
    #1;
    expOut = (expStat == 3) ? 0 : (keep ? p + f : p);
    chk({req, " R11 one status"}, stCnt == 1, stCnt, 1);
    chk({req, " status code"}, int'(stCode) == expStat, int'(stCode), expStat);
    chk({req, " R11 status timing"}, statCyc == eofCyc + 1, statCyc, eofCyc + 1);
    chk({req, " byte count"}, rxCnt == expOut, rxCnt, expOut);
    bad = 0;
    for (int i = 0; i < expOut && i < rxCnt; i++) if (rxData[i] !== frm[i]) bad++;
    chk({req, " byte values"}, bad == 0, bad, 0);
    if (expOut > 0) chk({req, " last position"}, lastCnt == 1 && lastIdx == expOut - 1,
                        lastIdx, expOut - 1);
    else chk({req, " no last"}, lastCnt == 0, lastCnt, 0);
  endtask

  task automatic tReset;
    chk("R12 outValid after reset", outValid == 1'b0, int'(outValid), 0);
    chk("R12 outLast after reset", outLast == 1'b0, int'(outLast), 0);
    chk("R12 statValid after reset", statValid == 1'b0, int'(statValid), 0);
  endtask

  task automatic tAddrMatch;
    cfgAddr = 8'h12; cfgCrcType = 2'd1; cfgRetCrc = 0; cfgRetCrcOnErr = 0;
    fillFrm(8'h12, 5);
    doFrame("R1 R5 match crc16 good", 5, 2, 0, 0, 1, 0);
  endtask

  task automatic tAddrMiss;
    fillFrm(8'h34, 5);
    doFrame("R2 address reject", 5, 2, 0, 0, 3, 0);
    fillFrm(8'h35, 1);
    cfgCrcType = 2'd0;
    doFrame("R2 one-byte reject", 1, 0, 0, 0, 3, 0);
    cfgCrcType = 2'd1;
  endtask

  task automatic tBroadcast;
    fillFrm(8'hFF, 4);
    doFrame("R3 broadcast accepted", 4, 2, 0, 0, 1, 0);
  endtask

  task automatic tPromisc;
    cfgAddr = 8'hFF;
    fillFrm(8'h55, 6);
    doFrame("R4 filter disabled", 6, 2, 0, 0, 1, 0);
    cfgAddr = 8'h12;
  endtask

  task automatic tCrc32;
    cfgCrcType = 2'd2;
    fillFrm(8'h12, 7);
    doFrame("R6 crc32 good", 7, 4, 1, 0, 1, 0);
    fillFrm(8'h12, 3);
    doFrame("R6 R8 crc32 bad", 3, 4, 1, 1, 2, 0);
    cfgCrcType = 2'd1;
  endtask

  task automatic tNoCrc;
    cfgCrcType = 2'd0;
    fillFrm(8'h12, 4);
    doFrame("R7 no check", 4, 0, 0, 0, 1, 0);
    fillFrm(8'h12, 1);
    doFrame("R7 one-byte frame", 1, 0, 0, 0, 1, 0);
    cfgCrcType = 2'd3;
    fillFrm(8'h12, 3);
    doFrame("R7 spare type", 3, 0, 0, 0, 1, 0);
    cfgCrcType = 2'd1;
  endtask

  task automatic tBadDefault;
    fillFrm(8'h12, 5);
    doFrame("R8 crc16 bad default", 5, 2, 0, 1, 2, 0);
  endtask

  task automatic tRetCrc;
    cfgRetCrc = 1;
    fillFrm(8'h12, 4);
    doFrame("R9 ret good crc16", 4, 2, 0, 0, 1, 1);
    fillFrm(8'h12, 4);
    doFrame("R9 ret bad crc16", 4, 2, 0, 1, 2, 1);
    cfgCrcType = 2'd2; cfgRetCrcOnErr = 1;
    fillFrm(8'h12, 5);
    doFrame("R9 ret good crc32 both set", 5, 4, 1, 0, 1, 1);
    cfgCrcType = 2'd1; cfgRetCrc = 0; cfgRetCrcOnErr = 0;
  endtask

  task automatic tRetOnErr;
    cfgRetCrcOnErr = 1;
    fillFrm(8'h12, 4);
    doFrame("R10 onerr bad crc16", 4, 2, 0, 1, 2, 1);
    fillFrm(8'h12, 4);
    doFrame("R10 onerr good crc16", 4, 2, 0, 0, 1, 0);
    cfgCrcType = 2'd2;
    fillFrm(8'h12, 6);
    doFrame("R10 onerr bad crc32", 6, 4, 1, 1, 2, 1);
    cfgCrcType = 2'd1; cfgRetCrcOnErr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    tReset();
    tAddrMatch();
    tAddrMiss();
    tBroadcast();
    tPromisc();
    tCrc32();
    tNoCrc();
    tBadDefault();
    tRetCrc();
    tRetOnErr();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule